// File: doc/BRIEF.md
# Command-Oriented I2C Target Interface

This block is the serial front end of a sensor-conditioning chip's control logic. It watches the two-wire bus lines from the system clock domain. It recognises START, repeated START and STOP. When the 7-bit device address matches, it accepts an 8-bit sub-address that names a register.

The register named by the sub-address sets how many data bytes follow the sub-address: none, one or two. Registers that take no bytes act as pure commands. These strobe as soon as the sub-address has been acknowledged. Data registers strobe only after their last byte has been acknowledged, and a STOP or START that arrives earlier throws the partial write away.

Reads use the usual write-sub-address, repeated-START, read-address sequence. The block asks the register file for a 16-bit word and shifts it out most-significant byte first.

Top module: `i2c_cmd_slave`

## Requirements
- R1: The device address is binary 11001 followed by the two bits of `dev_addr_lsb` (0x64 to 0x67; 0x67 with both bits set). Any other address gets no acknowledge, and the block keeps `sda_oe` low and issues no strobe until the next START.
- R2: Bit 0 of the address byte selects the direction. A 0 leads to a sub-address byte, and a 1 starts a read.
- R3: Each byte the block accepts is acknowledged by holding SDA low through the ninth SCL high phase. This covers the matching address byte, the sub-address and each write data byte. `sda_oe` only rises while SCL is low.
- R4: The number of payload bytes depends on the sub-address:
  - 0x06 and 0x07 take one byte.
  - 0x20, 0x22, 0x24, 0x25, 0x28, 0x2A, 0x2C and 0x2E take two bytes.
  - Every other sub-address takes none, including 0x00, 0x01, 0x04, 0x05, 0x08, the channel selects 0x10/0x12/0x14/0x15/0x18/0x1A/0x1C/0x1E and unused codes.
  - `cmd_nbytes` reports this count. `cmd_data` is zero when the count is 0, and its upper byte is zero when the count is 1.
- R5: A zero-byte sub-address gives one `cmd_valid` pulse when the sub-address acknowledge clock ends, before any STOP.
- R6: A data register strobes once, after its final byte has been acknowledged and not earlier. With two bytes, the first byte is `cmd_data[15:8]` and the second is `cmd_data[7:0]`.
- R7: A STOP or START that arrives before the final data byte discards the partial write, so no strobe is issued.
- R8: On a read, the block pulses `rd_req` with `rd_sub` equal to the last sub-address received. It then samples `rd_data` and sends bytes in this order:
  - for 0x02, 0x03 and the two-byte offset registers, `rd_data[15:8]` and then `rd_data[7:0]`;
  - for 0x06 and 0x07, `rd_data[7:0]` only;
  - 0x00 for every later byte.
  A master NACK ends the read with SDA released.
- R9: After reset `sda_oe`, `cmd_valid` and `rd_req` are low.
- R10: `cmd_valid` and `rd_req` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| dev_addr_lsb | input | 2 | Static low two bits of the device address |
| cmd_valid | output | 1 | One-cycle command/write strobe |
| cmd_sub | output | 8 | Sub-address of the strobed command |
| cmd_nbytes | output | 2 | Payload bytes carried (0, 1 or 2) |
| cmd_data | output | 16 | Payload, first byte in the upper half for two-byte registers |
| rd_req | output | 1 | One-cycle read request |
| rd_sub | output | 8 | Sub-address being read |
| rd_data | input | 16 | Register word, valid the cycle after `rd_req` |

## Verification
The bound checker watches the following on every cycle:
- single-cycle strobes and read requests;
- `sda_oe` rising only while SCL is low;
- the byte count of every strobe agreeing with the sub-address table, with no stray payload on zero-byte strobes;
- a strobe never firing while the block is still acknowledging;
- `rd_req` always coinciding with the start of an address acknowledge.

Some behaviours depend on whole bus sequences, so only the bench scenarios can show them:
- address matching against the configuration pins;
- when a strobe fires relative to the acknowledge and the STOP;
- discarding a write aborted by STOP or repeated START;
- the byte order of reads and writes.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam int SUB_W   = 8;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int CNT_W   = 2;
    localparam logic [4:0] DEV_ADDR_HI = 5'b11001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } eng_state_t;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_SUB,
        RX_DATA
    } rx_kind_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic is_offset_reg(input logic [SUB_W-1:0] sub);
        case (sub)
            8'h20, 8'h22, 8'h24, 8'h25, 8'h28, 8'h2A, 8'h2C, 8'h2E: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] payload_len(input logic [SUB_W-1:0] sub);
        if (is_offset_reg(sub))
            return 2'd2;
        else if (sub == 8'h06 || sub == 8'h07)
            return 2'd1;
        else
            return 2'd0;
    endfunction

    function automatic logic [CNT_W-1:0] read_len(input logic [SUB_W-1:0] sub);
        if (is_offset_reg(sub) || sub == 8'h02 || sub == 8'h03)
            return 2'd2;
        else if (sub == 8'h06 || sub == 8'h07)
            return 2'd1;
        else
            return 2'd0;
    endfunction

    function automatic logic [BYTE_W-1:0] read_byte(input logic [WORD_W-1:0] word,
                                                    input logic [CNT_W-1:0] len,
                                                    input logic [CNT_W-1:0] idx);
        if (idx == 2'd0 && len == 2'd2)
            return word[15:8];
        else if ((idx == 2'd0 && len == 2'd1) || (idx == 2'd1 && len == 2'd2))
            return word[7:0];
        else
            return 8'h00;
    endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    import i2c_cmd_pkg::*;

    localparam int SYNC_N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [SYNC_N-1:0] sync_q;
    logic [2:0]        win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            win_q  <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], din};
            win_q  <= {win_q[1:0], sync_q[SYNC_N-1]};
            dout   <= maj3(win_q);
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_f,
    input  logic                  sda_f,
    output i2c_cmd_pkg::bus_ev_t  ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.start    = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop     = scl_f & scl_q & ~sda_q & sda_f;
        ev.scl_rise = scl_f & ~scl_q;
        ev.scl_fall = ~scl_f & scl_q;
        ev.sda      = sda_f;
    end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
    import i2c_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bus_ev_t             ev,
    input  logic [1:0]          dev_addr_lsb,
    input  logic [WORD_W-1:0]   rd_data,
    output logic                sda_oe,
    output logic                cmd_valid,
    output logic [SUB_W-1:0]    cmd_sub,
    output logic [CNT_W-1:0]    cmd_nbytes,
    output logic [WORD_W-1:0]   cmd_data,
    output logic                rd_req,
    output logic [SUB_W-1:0]    rd_sub
);
    eng_state_t         state;
    rx_kind_t           rx_kind;
    logic [2:0]         bitcnt;
    logic               full;
    logic [BYTE_W-1:0]  sh;
    logic               rw;
    logic [SUB_W-1:0]   sub_q;
    logic [CNT_W-1:0]   need;
    logic [CNT_W-1:0]   got;
    logic [WORD_W-1:0]  data_q;
    logic [BYTE_W-1:0]  tx;
    logic [WORD_W-1:0]  rd_word;
    logic [CNT_W-1:0]   rd_idx;
    logic               mnack;
    logic [BYTE_W-1:0]  next_tx;

    assign next_tx = read_byte(rd_word, read_len(sub_q), rd_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            rx_kind    <= RX_DEV;
            bitcnt     <= '0;
            full       <= 1'b0;
            sh         <= '0;
            rw         <= 1'b0;
            sub_q      <= '0;
            need       <= '0;
            got        <= '0;
            data_q     <= '0;
            tx         <= '0;
            rd_word    <= '0;
            rd_idx     <= '0;
            mnack      <= 1'b1;
            sda_oe     <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_sub    <= '0;
            cmd_nbytes <= '0;
            cmd_data   <= '0;
            rd_req     <= 1'b0;
            rd_sub     <= '0;
        end else begin
            cmd_valid <= 1'b0;
            rd_req    <= 1'b0;
            if (rd_req)
                rd_word <= rd_data;

            if (ev.start) begin
                state   <= ST_RX;
                rx_kind <= RX_DEV;
                bitcnt  <= '0;
                full    <= 1'b0;
                got     <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (ev.scl_rise && !full) begin
                            sh     <= {sh[6:0], ev.sda};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7)
                                full <= 1'b1;
                        end else if (ev.scl_fall && full) begin
                            full   <= 1'b0;
                            bitcnt <= '0;
                            case (rx_kind)
                                RX_DEV: begin
                                    if (sh[7:1] == {DEV_ADDR_HI, dev_addr_lsb}) begin
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                        rw     <= sh[0];
                                        if (sh[0]) begin
                                            rd_req <= 1'b1;
                                            rd_sub <= sub_q;
                                            rd_idx <= '0;
                                        end
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                RX_SUB: begin
                                    sub_q  <= sh;
                                    need   <= payload_len(sh);
                                    got    <= '0;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end
                                default: begin
                                    data_q <= {data_q[7:0], sh};
                                    got    <= got + 2'd1;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            case (rx_kind)
                                RX_DEV: begin
                                    if (rw) begin
                                        tx     <= next_tx;
                                        sda_oe <= ~next_tx[7];
                                        bitcnt <= '0;
                                        state  <= ST_TX;
                                    end else begin
                                        rx_kind <= RX_SUB;
                                        state   <= ST_RX;
                                    end
                                end
                                RX_SUB: begin
                                    if (need == 2'd0) begin
                                        cmd_valid  <= 1'b1;
                                        cmd_sub    <= sub_q;
                                        cmd_nbytes <= 2'd0;
                                        cmd_data   <= '0;
                                        state      <= ST_IDLE;
                                    end else begin
                                        data_q  <= '0;
                                        rx_kind <= RX_DATA;
                                        state   <= ST_RX;
                                    end
                                end
                                default: begin
                                    if (got == need) begin
                                        cmd_valid  <= 1'b1;
                                        cmd_sub    <= sub_q;
                                        cmd_nbytes <= need;
                                        cmd_data   <= data_q;
                                        state      <= ST_IDLE;
                                    end else begin
                                        state <= ST_RX;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                                if (rd_idx != 2'd3)
                                    rd_idx <= rd_idx + 2'd1;
                            end else begin
                                sda_oe <= ~tx[6];
                                tx     <= {tx[6:0], 1'b0};
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            mnack <= ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mnack) begin
                                state <= ST_IDLE;
                            end else begin
                                tx     <= next_tx;
                                sda_oe <= ~next_tx[7];
                                bitcnt <= '0;
                                state  <= ST_TX;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave #(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [1:0]  dev_addr_lsb,
    output logic        cmd_valid,
    output logic [7:0]  cmd_sub,
    output logic [1:0]  cmd_nbytes,
    output logic [15:0] cmd_data,
    output logic        rd_req,
    output logic [7:0]  rd_sub,
    input  logic [15:0] rd_data
);
    import i2c_cmd_pkg::*;

    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] filt_lines;
    bus_ev_t          ev;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_filt
        i2c_glitch_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    i2c_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_f (filt_lines[0]),
        .sda_f (filt_lines[1]),
        .ev    (ev)
    );

    i2c_cmd_engine u_engine (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .dev_addr_lsb (dev_addr_lsb),
        .rd_data      (rd_data),
        .sda_oe       (sda_oe),
        .cmd_valid    (cmd_valid),
        .cmd_sub      (cmd_sub),
        .cmd_nbytes   (cmd_nbytes),
        .cmd_data     (cmd_data),
        .rd_req       (rd_req),
        .rd_sub       (rd_sub)
    );
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        scl_i,
    input logic        sda_oe,
    input logic        cmd_valid,
    input logic [7:0]  cmd_sub,
    input logic [1:0]  cmd_nbytes,
    input logic [15:0] cmd_data,
    input logic        rd_req
);
    import i2c_cmd_pkg::*;

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R10
    rdreq_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R3
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    // R4
    nbytes_table_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_nbytes == payload_len(cmd_sub));

    // R4
    empty_payload_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_nbytes == 2'd0) |-> cmd_data == 16'h0000);

    // R6
    strobe_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !sda_oe);

    // R8
    rdreq_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> sda_oe);
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_oe     (sda_oe),
    .cmd_valid  (cmd_valid),
    .cmd_sub    (cmd_sub),
    .cmd_nbytes (cmd_nbytes),
    .cmd_data   (cmd_data),
    .rd_req     (rd_req)
);

// File: tb/i2c_cmd_slave_bench.sv
module i2c_cmd_slave_bench;

    localparam int HALF = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m_low = 1'b0;
    logic        sda_line;
    logic        sda_oe;
    logic [1:0]  addr_lsb = 2'b11;
    logic        cmd_valid;
    logic [7:0]  cmd_sub;
    logic [1:0]  cmd_nbytes;
    logic [15:0] cmd_data;
    logic        rd_req;
    logic [7:0]  rd_sub;
    logic [15:0] rd_data;

    typedef struct {
        logic [7:0]  sub;
        logic [1:0]  n;
        logic [15:0] d;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   strobes = 0;
    int   rdreqs = 0;
    logic [7:0] exp_rd_sub = 8'h00;
    bit   done = 0;

    always #2 clk = ~clk;

    assign sda_line = !(sda_m_low || sda_oe);
    assign rd_data  = {rd_sub ^ 8'h5A, ~rd_sub};

    i2c_cmd_slave u_i2c_cmd_slave (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe       (sda_oe),
        .dev_addr_lsb (addr_lsb),
        .cmd_valid    (cmd_valid),
        .cmd_sub      (cmd_sub),
        .cmd_nbytes   (cmd_nbytes),
        .cmd_data     (cmd_data),
        .rd_req       (rd_req),
        .rd_sub       (rd_sub),
        .rd_data      (rd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference model: every clock compare strobes against the expected queue
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            strobes++;
            if (q.size() == 0) begin
                chk(0, "R7 unexpected strobe", int'(cmd_sub), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(cmd_sub == e.sub, "R4 strobe sub", int'(cmd_sub), int'(e.sub));
                chk(cmd_nbytes == e.n, "R4 strobe nbytes", int'(cmd_nbytes), int'(e.n));
                chk(cmd_data == e.d, "R6 strobe data", int'(cmd_data), int'(e.d));
            end
        end
        if (!rst && rd_req) begin
            rdreqs++;
            chk(rd_sub == exp_rd_sub, "R8 rd_sub", int'(rd_sub), int'(exp_rd_sub));
        end
    end

    task automatic i2c_start();
        waitc(8); sda_m_low = 1'b0;
        waitc(HALF - 8); scl_m = 1'b1;
        waitc(HALF); sda_m_low = 1'b1;
        waitc(HALF); scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        waitc(8); sda_m_low = 1'b1;
        waitc(HALF - 8); scl_m = 1'b1;
        waitc(HALF); sda_m_low = 1'b0;
        waitc(HALF);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            waitc(8); sda_m_low = !b[i];
            waitc(HALF - 8); scl_m = 1'b1;
            waitc(HALF); scl_m = 1'b0;
        end
        waitc(8); sda_m_low = 1'b0;
        waitc(HALF - 8); scl_m = 1'b1;
        waitc(HALF / 2); acked = !sda_line;
        waitc(HALF / 2); scl_m = 1'b0;
    endtask

    task automatic rd_byte(input bit nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            waitc(8); sda_m_low = 1'b0;
            waitc(HALF - 8); scl_m = 1'b1;
            waitc(HALF / 2); b[i] = sda_line;
            waitc(HALF / 2); scl_m = 1'b0;
        end
        waitc(8); sda_m_low = !nack;
        waitc(HALF - 8); scl_m = 1'b1;
        waitc(HALF); scl_m = 1'b0;
    endtask

    task automatic expect_cmd(input logic [7:0] s, input logic [1:0] n, input logic [15:0] d);
        exp_t e;
        e.sub = s; e.n = n; e.d = d;
        q.push_back(e);
    endtask

    initial begin
        bit a;
        logic [7:0] rb;
        int s0;

        waitc(5);
        // R9 reset state
        chk(sda_oe == 0, "R9 sda_oe in reset", int'(sda_oe), 0);
        chk(cmd_valid == 0, "R9 cmd_valid in reset", int'(cmd_valid), 0);
        rst = 1'b0;
        waitc(5);
        chk(sda_oe == 0 && rd_req == 0, "R9 idle after reset", int'(sda_oe), 0);

        // R2 R3 R6: one-byte write to 0x06
        expect_cmd(8'h06, 2'd1, 16'h0004);
        i2c_start();
        wr_byte(8'hCE, a); chk(a, "R3 ack address", int'(a), 1);
        wr_byte(8'h06, a); chk(a, "R2 ack sub after write bit", int'(a), 1);
        s0 = strobes;
        wr_byte(8'h04, a); chk(a, "R3 ack data", int'(a), 1);
        waitc(12);
        chk(strobes == s0 + 1, "R6 strobe after final ack", strobes, s0 + 1);
        i2c_stop();

        // R5: channel select 0x15 strobes before STOP
        expect_cmd(8'h15, 2'd0, 16'h0000);
        i2c_start();
        wr_byte(8'hCE, a);
        s0 = strobes;
        wr_byte(8'h15, a); chk(a, "R3 ack sub", int'(a), 1);
        waitc(12);
        chk(strobes == s0 + 1, "R5 zero-byte strobe before STOP", strobes, s0 + 1);
        i2c_stop();

        // R6: two-byte offset register, high byte first
        expect_cmd(8'h25, 2'd2, 16'h0489);
        i2c_start();
        wr_byte(8'hCE, a);
        wr_byte(8'h25, a);
        s0 = strobes;
        wr_byte(8'h04, a);
        waitc(12);
        chk(strobes == s0, "R6 no strobe after first byte", strobes, s0);
        wr_byte(8'h89, a); chk(a, "R3 ack second data", int'(a), 1);
        waitc(12);
        chk(strobes == s0 + 1, "R6 strobe after second byte", strobes, s0 + 1);
        i2c_stop();

        // R7: STOP mid payload, then repeated START mid payload
        s0 = strobes;
        i2c_start();
        wr_byte(8'hCE, a);
        wr_byte(8'h2C, a);
        wr_byte(8'h11, a);
        i2c_stop();
        waitc(20);
        chk(strobes == s0, "R7 STOP discards partial write", strobes, s0);
        expect_cmd(8'h07, 2'd1, 16'h0002);
        i2c_start();
        wr_byte(8'hCE, a);
        wr_byte(8'h2A, a);
        wr_byte(8'h33, a);
        i2c_start();
        wr_byte(8'hCE, a);
        wr_byte(8'h07, a);
        wr_byte(8'h02, a);
        i2c_stop();
        waitc(20);
        chk(strobes == s0 + 1, "R7 repeated START discards partial write", strobes, s0 + 1);

        // R1: wrong address is ignored
        s0 = strobes;
        i2c_start();
        wr_byte(8'hC0, a); chk(!a, "R1 nack foreign address", int'(a), 0);
        wr_byte(8'h15, a); chk(!a, "R1 ignored until START", int'(a), 0);
        i2c_stop();
        i2c_start();
        wr_byte(8'hC8, a); chk(!a, "R1 0x64 nack with lsb=3", int'(a), 0);
        i2c_stop();
        waitc(20);
        chk(strobes == s0, "R1 no strobe on mismatch", strobes, s0);
        addr_lsb = 2'b00;
        expect_cmd(8'h01, 2'd0, 16'h0000);
        i2c_start();
        wr_byte(8'hC8, a); chk(a, "R1 0x64 ack with lsb=0", int'(a), 1);
        wr_byte(8'h01, a);
        i2c_stop();
        i2c_start();
        wr_byte(8'hCE, a); chk(!a, "R1 0x67 nack with lsb=0", int'(a), 0);
        i2c_stop();
        addr_lsb = 2'b11;

        // R4: unlisted sub-address behaves as a zero-byte command
        expect_cmd(8'h40, 2'd0, 16'h0000);
        i2c_start();
        wr_byte(8'hCE, a);
        wr_byte(8'h40, a);
        i2c_stop();
        waitc(20);
        chk(q.size() == 0, "R4 unlisted sub strobed", q.size(), 0);

        // R8 R2: two-byte read of 0x25
        s0 = rdreqs;
        exp_rd_sub = 8'h25;
        i2c_start();
        wr_byte(8'hCE, a);
        wr_byte(8'h25, a);
        i2c_start();
        wr_byte(8'hCF, a); chk(a, "R2 ack read address", int'(a), 1);
        chk(rdreqs == s0 + 1, "R8 one read request", rdreqs, s0 + 1);
        rd_byte(1'b0, rb); chk(rb == (8'h25 ^ 8'h5A), "R8 read high byte", int'(rb), int'(8'h25 ^ 8'h5A));
        rd_byte(1'b1, rb); chk(rb == 8'hDA, "R8 read low byte", int'(rb), 32'hDA);
        waitc(12);
        chk(sda_oe == 0, "R8 released after NACK", int'(sda_oe), 0);
        i2c_stop();

        // R8: one-byte read of 0x07, trailing byte is zero
        exp_rd_sub = 8'h07;
        i2c_start();
        wr_byte(8'hCE, a);
        wr_byte(8'h07, a);
        i2c_start();
        wr_byte(8'hCF, a);
        rd_byte(1'b0, rb); chk(rb == 8'hF8, "R8 one-byte reg low byte", int'(rb), 32'hF8);
        rd_byte(1'b1, rb); chk(rb == 8'h00, "R8 byte beyond length", int'(rb), 0);
        i2c_stop();

        waitc(50);
        chk(q.size() == 0, "R6 all expected strobes seen", q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule